// File: doc/BRIEF.md
# Host-Target Mailbox Command Decoder

This block is a memory-mapped mailbox through which a simulated target hands commands to the host side of a test environment. The target stores a word of 1 to 8 bytes into a single mailbox register. The stored value is zero-extended to 64 bits, and the block then splits it into a device code, a command code and a payload.

Two actions are decoded. An exit request to the system-call device sets a sticky done flag and captures an exit code. A write command to the terminal device emits one character on a valid/data output that lasts one cycle. Any other code is stored and has no further effect.

Loads return the mailbox contents, and only full-width loads are accepted. A periodic tick input acknowledges the command by clearing the mailbox.

Top module: `hostlink_mailbox`

## Requirements
- R1: A store of N bytes (N from 1 to 8, given on `wr_bytes`) writes the low 8*N bits of `wr_data` into the mailbox and clears the bits above them. The new value can be read on the next cycle.
- R2: A store with `wr_bytes` equal to 0 or greater than 8 leaves the mailbox unchanged and causes no action.
- R3: The stored word is decoded with the device code in bits 63:56, the command code in bits 55:48 and the payload in bits 47:0. A store with device 0x00 and payload bit 0 set raises `done` on the next cycle and sets `exit_code` to payload bits 47:1.
- R4: `done` stays high until reset. `exit_code` keeps the value from the first exit request, and later exit requests or ticks do not change it.
- R5: A store with device 0x00 and payload bit 0 clear has no side effect.
- R6: A store with device 0x01 and command 0x01 raises `chr_valid` for exactly one cycle, on the next cycle, with `chr_data` equal to payload bits 7:0.
- R7: A store with device 0x01 and command 0x00, or with any other device or command code, is stored but raises neither `chr_valid` nor `done`.
- R8: While `rd_en` is high with `rd_bytes` equal to 8, `rd_data` shows the mailbox and `rd_fault` is low. While `rd_en` is high with any other width, `rd_fault` is high and `rd_data` is zero. While `rd_en` is low, `rd_fault` is low.
- R9: A tick without a store clears the mailbox to zero on the next cycle. A valid store in the same cycle as a tick takes priority over the tick.
- R10: After reset the mailbox reads zero, and `done`, `exit_code` and `chr_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Store strobe |
| wr_bytes | input | 4 | Store width in bytes |
| wr_data | input | 64 | Store data, right-aligned |
| rd_en | input | 1 | Load strobe |
| rd_bytes | input | 4 | Load width in bytes |
| rd_data | output | 64 | Load result |
| rd_fault | output | 1 | Load access fault |
| tick | input | 1 | Acknowledge pulse that clears the mailbox |
| done | output | 1 | Sticky test-done flag |
| exit_code | output | 47 | Captured exit code |
| chr_valid | output | 1 | Character output valid, one cycle |
| chr_data | output | 8 | Character output byte |

## Verification
The bench builds the block with its default parameters: a 64-bit word, 8-bit device and command fields, device 0x00 for the system-call device, device 0x01 for the terminal, and command 0x01 for a terminal write. With these values the 4-bit width inputs can carry every legal store width from 1 to 8, and also the illegal widths 0 and 9. Short stores zero the device field, so a one-byte store can issue an exit request. The 47-bit exit code is wide enough to show that it is taken from the payload shifted right by one bit.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_EXIT = 2'd1,
    ACT_PUTC = 2'd2
  } mbox_act_e;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/mbox_store_fmt.sv
module mbox_store_fmt #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned BCNT_W = 4
) (
  input  logic [BCNT_W-1:0] st_bytes,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_ok,
  output logic [DATA_W-1:0] st_word
);
  localparam int unsigned NBYTES = DATA_W / 8;

  assign st_ok = (st_bytes != '0) && (st_bytes <= BCNT_W'(NBYTES));

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign st_word[8*b +: 8] = (st_bytes > BCNT_W'(b)) ? st_data[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned DEV_W    = 8,
  parameter int unsigned CMD_W    = 8,
  parameter int unsigned DEV_SYS  = 0,
  parameter int unsigned DEV_TERM = 1,
  parameter int unsigned CMD_PUTC = 1,
  localparam int unsigned PAY_W   = DATA_W - DEV_W - CMD_W
) (
  input  logic [DATA_W-1:0] word,
  output mbox_act_e         act,
  output logic [PAY_W-1:0]  payload
);
  logic [DEV_W-1:0] dev;
  logic [CMD_W-1:0] cmd;

  assign dev     = word[DATA_W-1 -: DEV_W];
  assign cmd     = word[PAY_W +: CMD_W];
  assign payload = word[PAY_W-1:0];

  always_comb begin
    act = ACT_NONE;
    if (dev == DEV_W'(DEV_SYS)) begin
      if (payload[0]) act = ACT_EXIT;
    end else if (dev == DEV_W'(DEV_TERM)) begin
      if (cmd == CMD_W'(CMD_PUTC)) act = ACT_PUTC;
    end
  end
endmodule

// File: rtl/hostlink_mailbox.sv
module hostlink_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned DEV_W    = 8,
  parameter int unsigned CMD_W    = 8,
  parameter int unsigned CHR_W    = 8,
  parameter int unsigned DEV_SYS  = 0,
  parameter int unsigned DEV_TERM = 1,
  parameter int unsigned CMD_PUTC = 1,
  localparam int unsigned NBYTES  = DATA_W / 8,
  localparam int unsigned BCNT_W  = $clog2(NBYTES) + 1,
  localparam int unsigned PAY_W   = DATA_W - DEV_W - CMD_W,
  localparam int unsigned EXIT_W  = PAY_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BCNT_W-1:0] wr_bytes,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [BCNT_W-1:0] rd_bytes,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_fault,
  input  logic              tick,
  output logic              done,
  output logic [EXIT_W-1:0] exit_code,
  output logic              chr_valid,
  output logic [CHR_W-1:0]  chr_data
);
  logic              rst_ns;
  logic              st_ok;
  logic [DATA_W-1:0] st_word;
  mbox_act_e         act;
  logic [PAY_W-1:0]  payload;

  logic [DATA_W-1:0] mbox_q, mbox_d;
  logic              mbox_en;
  logic              done_q, done_d;
  logic [EXIT_W-1:0] exit_q, exit_d;
  logic              exit_en;
  logic              cv_q, cv_d;
  logic [CHR_W-1:0]  cd_q, cd_d;
  logic              cd_en;
  logic              st_fire;
  logic              rd_ok;

  mbox_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  mbox_store_fmt #(.DATA_W(DATA_W), .BCNT_W(BCNT_W)) u_fmt (
    .st_bytes (wr_bytes),
    .st_data  (wr_data),
    .st_ok    (st_ok),
    .st_word  (st_word)
  );

  mbox_decode #(
    .DATA_W(DATA_W), .DEV_W(DEV_W), .CMD_W(CMD_W),
    .DEV_SYS(DEV_SYS), .DEV_TERM(DEV_TERM), .CMD_PUTC(CMD_PUTC)
  ) u_dec (
    .word    (st_word),
    .act     (act),
    .payload (payload)
  );

  // next-state logic
  always_comb begin
    st_fire = wr_en && st_ok;
    mbox_en = st_fire || tick;
    mbox_d  = st_fire ? st_word : '0;
    exit_en = st_fire && (act == ACT_EXIT) && !done_q;
    done_d  = done_q || exit_en;
    exit_d  = payload[PAY_W-1:1];
    cv_d    = st_fire && (act == ACT_PUTC);
    cd_en   = cv_d;
    cd_d    = payload[CHR_W-1:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      mbox_q <= '0;
      done_q <= 1'b0;
      exit_q <= '0;
      cv_q   <= 1'b0;
      cd_q   <= '0;
    end else begin
      if (mbox_en) mbox_q <= mbox_d;
      done_q <= done_d;
      if (exit_en) exit_q <= exit_d;
      cv_q <= cv_d;
      if (cd_en) cd_q <= cd_d;
    end
  end

  assign rd_ok     = (rd_bytes == BCNT_W'(NBYTES));
  assign rd_data   = (rd_en && rd_ok) ? mbox_q : '0;
  assign rd_fault  = rd_en && !rd_ok;
  assign done      = done_q;
  assign exit_code = exit_q;
  assign chr_valid = cv_q;
  assign chr_data  = cd_q;
endmodule

// File: rtl/hostlink_mailbox_chk.sv
module hostlink_mailbox_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned BCNT_W = 4,
  parameter int unsigned EXIT_W = 47
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              wr_en,
  input logic [BCNT_W-1:0] wr_bytes,
  input logic [DATA_W-1:0] wr_data,
  input logic              tick,
  input logic [DATA_W-1:0] mbox,
  input logic              rd_en,
  input logic [BCNT_W-1:0] rd_bytes,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_fault,
  input logic              done,
  input logic [EXIT_W-1:0] exit_code,
  input logic              chr_valid
);
  localparam int unsigned NBYTES = DATA_W / 8;

  AST_FULL_STORE: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && wr_bytes == BCNT_W'(NBYTES)) |=> (mbox == $past(wr_data))); // R1
  AST_BAD_WIDTH_KEEPS: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && !tick && (wr_bytes == '0 || wr_bytes > BCNT_W'(NBYTES))) |=> $stable(mbox)); // R2
  AST_TICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_ns)
    (tick && !wr_en) |=> (mbox == '0)); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> (done && $stable(exit_code))); // R4
  AST_CHR_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_ns)
    chr_valid |-> $past(wr_en)); // R6
  AST_LOAD_FAULT: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_en && rd_bytes != BCNT_W'(NBYTES)) |-> (rd_fault && rd_data == '0)); // R8
  AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_en && rd_bytes == BCNT_W'(NBYTES)) |-> (!rd_fault && rd_data == mbox)); // R8
  AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_ns)
    !rd_en |-> !rd_fault); // R8
endmodule

bind hostlink_mailbox hostlink_mailbox_chk #(
  .DATA_W(DATA_W), .BCNT_W(BCNT_W), .EXIT_W(EXIT_W)
) u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .wr_en     (wr_en),
  .wr_bytes  (wr_bytes),
  .wr_data   (wr_data),
  .tick      (tick),
  .mbox      (mbox_q),
  .rd_en     (rd_en),
  .rd_bytes  (rd_bytes),
  .rd_data   (rd_data),
  .rd_fault  (rd_fault),
  .done      (done),
  .exit_code (exit_code),
  .chr_valid (chr_valid)
);

// File: tb/tb_hostlink_mailbox.sv
module tb_hostlink_mailbox;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_bytes;
  logic [63:0] wr_data;
  logic        rd_en;
  logic [3:0]  rd_bytes;
  logic [63:0] rd_data;
  logic        rd_fault;
  logic        tick;
  logic        done;
  logic [46:0] exit_code;
  logic        chr_valid;
  logic [7:0]  chr_data;

  int n_checks = 0;
  int n_fail   = 0;

  hostlink_mailbox dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bytes(wr_bytes), .wr_data(wr_data),
    .rd_en(rd_en), .rd_bytes(rd_bytes), .rd_data(rd_data), .rd_fault(rd_fault),
    .tick(tick), .done(done), .exit_code(exit_code),
    .chr_valid(chr_valid), .chr_data(chr_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0]  nb;
    logic [63:0] data;
    logic [63:0] exp_rb;
    logic        exp_cv;
    logic [7:0]  exp_cd;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{4'd8, 64'h0101_0000_0000_0041, 64'h0101_0000_0000_0041, 1'b1, 8'h41},
    '{4'd8, 64'h0100_0000_0000_0042, 64'h0100_0000_0000_0042, 1'b0, 8'h00},
    '{4'd4, 64'h0101_0000_0000_0044, 64'h0000_0000_0000_0044, 1'b0, 8'h00},
    '{4'd2, 64'hFFFF_FFFF_FFFF_1234, 64'h0000_0000_0000_1234, 1'b0, 8'h00},
    '{4'd8, 64'h0201_0000_0000_0055, 64'h0201_0000_0000_0055, 1'b0, 8'h00},
    '{4'd8, 64'h0102_0000_0000_0066, 64'h0102_0000_0000_0066, 1'b0, 8'h00},
    '{4'd1, 64'h0000_0000_0000_ABCE, 64'h0000_0000_0000_00CE, 1'b0, 8'h00},
    '{4'd8, 64'h0101_0000_0000_00FF, 64'h0101_0000_0000_00FF, 1'b1, 8'hFF},
    '{4'd3, 64'h0101_00AB_CDEF_1230, 64'h0000_0000_00EF_1230, 1'b0, 8'h00}
  };

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one store at a negedge, return at the negedge after the capturing posedge
  task automatic store(input logic [3:0] nb, input logic [63:0] d, input logic tk);
    wr_en = 1'b1; wr_bytes = nb; wr_data = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; wr_bytes = 4'd0; wr_data = '0; tick = 1'b0;
  endtask

  task automatic readback(output logic [63:0] v);
    rd_en = 1'b1; rd_bytes = 4'd8;
    #1;
    v = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    summary();
    $finish;
  end

  initial begin
    logic [63:0] v;
    wr_en = 0; wr_bytes = 0; wr_data = 0; rd_en = 0; rd_bytes = 0; tick = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    readback(v);
    check(v == 64'd0, "R10 mailbox after reset", v, 64'd0);
    check(done == 1'b0 && exit_code == '0, "R10 done/exit after reset", {done, 16'd0, exit_code}, 64'd0);
    check(chr_valid == 1'b0, "R10 chr_valid after reset", 64'(chr_valid), 64'd0);

    // table of stores: R1 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      store(VEC[i].nb, VEC[i].data, 1'b0);
      check(chr_valid == VEC[i].exp_cv, "R6/R7 chr_valid after store", 64'(chr_valid), 64'(VEC[i].exp_cv));
      if (VEC[i].exp_cv)
        check(chr_data == VEC[i].exp_cd, "R6 chr_data", 64'(chr_data), 64'(VEC[i].exp_cd));
      readback(v);
      check(v == VEC[i].exp_rb, "R1 zero-extended readback", v, VEC[i].exp_rb);
      check(done == 1'b0, "R5 no exit from non-exit store", 64'(done), 64'd0);
    end

    // R6 pulse lasts one cycle
    store(4'd8, 64'h0101_0000_0000_005A, 1'b0);
    check(chr_valid == 1'b1 && chr_data == 8'h5A, "R6 terminal write", {55'd0, chr_valid, chr_data}, 64'h15A);
    @(negedge clk);
    check(chr_valid == 1'b0, "R6 pulse one cycle", 64'(chr_valid), 64'd0);

    // R2 illegal widths
    store(4'd8, 64'h0300_0000_0000_1111, 1'b0);
    store(4'd0, 64'h0101_0000_0000_0041, 1'b0);
    check(chr_valid == 1'b0, "R2 width 0 no action", 64'(chr_valid), 64'd0);
    readback(v);
    check(v == 64'h0300_0000_0000_1111, "R2 width 0 keeps mailbox", v, 64'h0300_0000_0000_1111);
    store(4'd9, 64'h0000_0000_0000_0003, 1'b0);
    check(done == 1'b0, "R2 width 9 no exit", 64'(done), 64'd0);
    readback(v);
    check(v == 64'h0300_0000_0000_1111, "R2 width 9 keeps mailbox", v, 64'h0300_0000_0000_1111);

    // R9 tick clears; store wins over tick
    rd_en = 0; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    readback(v);
    check(v == 64'd0, "R9 tick clears mailbox", v, 64'd0);
    store(4'd8, 64'h0101_0000_0000_0077, 1'b1);
    check(chr_valid == 1'b1, "R9 store with tick still decoded", 64'(chr_valid), 64'd1);
    readback(v);
    check(v == 64'h0101_0000_0000_0077, "R9 store wins over tick", v, 64'h0101_0000_0000_0077);

    // R8 loads
    rd_en = 1'b1; rd_bytes = 4'd4; #1;
    check(rd_fault == 1'b1 && rd_data == 64'd0, "R8 4-byte load faults", {63'd0, rd_fault} | rd_data, 64'd1);
    rd_bytes = 4'd0; #1;
    check(rd_fault == 1'b1, "R8 0-byte load faults", 64'(rd_fault), 64'd1);
    rd_bytes = 4'd8; #1;
    check(rd_fault == 1'b0 && rd_data == 64'h0101_0000_0000_0077, "R8 8-byte load", rd_data, 64'h0101_0000_0000_0077);
    rd_en = 1'b0; rd_bytes = 4'd4; #1;
    check(rd_fault == 1'b0, "R8 no fault when idle", 64'(rd_fault), 64'd0);

    // R3 R4 exit
    store(4'd8, 64'h0000_0000_0000_0007, 1'b0);
    check(done == 1'b1, "R3 exit sets done", 64'(done), 64'd1);
    check(exit_code == 47'd3, "R3 exit code", 64'(exit_code), 64'd3);
    store(4'd8, 64'h0000_0000_0000_0011, 1'b0);
    check(exit_code == 47'd3, "R4 later exit ignored", 64'(exit_code), 64'd3);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    check(done == 1'b1 && exit_code == 47'd3, "R4 done sticky over tick", {done, 16'd0, exit_code}, {1'b1, 16'd0, 47'd3});

    // R10 reset clears done; R1/R3 short store reaches device 0
    do_reset();
    check(done == 1'b0 && exit_code == '0, "R10 reset clears done", {done, 16'd0, exit_code}, 64'd0);
    store(4'd1, 64'hFF00_0000_0000_FF0B, 1'b0);
    check(done == 1'b1 && exit_code == 47'd5, "R3 one-byte exit code", 64'(exit_code), 64'd5);
    readback(v);
    check(v == 64'h0B, "R1 one-byte zero-extension", v, 64'h0B);

    summary();
    $finish;
  end
endmodule